// File: doc/BRIEF.md
# ATA Drive Timing Word Generator

This block turns the transfer modes chosen for the two drives on one ATA channel into the packed timing words that a channel's strobe timer consumes. For each drive it takes a presence flag, flags that enable multiword DMA and Ultra DMA, and the programmed I/O, multiword DMA and Ultra DMA mode numbers. It looks up the minimum cycle and active times in nanoseconds for each mode and converts every time to controller ticks by ceiling division. One shared sequential divider does all twelve divisions. It then derives the recovery counts and packs everything into one 32-bit word per drive.

Two variants are picked by an input that is sampled at the start of a request. The legacy variant counts in 30 ns ticks, applies recovery offsets and minimum clamps, and has no Ultra DMA field. The fast variant counts in 15 ns ticks, uses plain cycle-minus-active recovery, and adds an Ultra DMA field. After both words are packed, the block decides which word the channel's single timing register holds. It also decides whether that register has to be reloaded on every drive select, because the two drives need different timing.

A request is a one-cycle `start` pulse while the block is idle. The results stay on the outputs until the next request completes, and `done` pulses once per request.

Top module: `ata_timing_gen`

## Requirements
- R1: After reset, `done`, `word0`, `word1`, `timing_reg` and `switch_en` are all zero.
- R2: Legacy variant (`fast_mode`=0), I/O part of a word. The mode times are, as cycle/active in ns: mode 0 600/180, mode 1 390/150, mode 2 240/105, mode 3 180/90, mode 4 120/75. Each time becomes ceil(ns/30) ticks. The active count is raised to at least 1 and is placed at bit 0. The recovery count is cycle minus active minus 4, raised to at least 1, and is placed at bit 5. This part lies within bits 10..0.
- R3: Legacy variant, multiword DMA part, present only when the drive's DMA flag is set. The mode times are, as cycle/active in ns: mode 0 480/240, mode 1 165/90, mode 2 120/75. Ticks are ceil(ns/30). The active count goes at bit 11. The recovery count is cycle minus active minus 1, raised to at least 1, and goes at bit 16. Bit 21 is 0. The Ultra DMA flag has no effect in this variant, so bits 31..21 stay 0.
- R4: Fast variant (`fast_mode`=1). Ticks are ceil(ns/15) and recovery is cycle minus active, with no offset and no clamp. The I/O part has active at bit 0 and recovery at bit 5. The DMA part, present only when the DMA flag is set, has active at bit 10 and recovery at bit 15.
- R5: Fast variant with the Ultra DMA flag set. The mode times are, as cycle/active in ns: mode 0 120/180, mode 1 90/150, mode 2 60/120, mode 3 45/90, mode 4 30/90. Cycle ticks go at bit 21, active ticks at bit 25, and bit 20 is set to 1.
- R6: A drive whose presence flag is 0 yields a zero word, whatever its other flags and modes are. When the drive is present, the DMA part and the Ultra DMA part are included only when their own flags are set.
- R7: Mode numbers above the highest table entry use the highest entry. An I/O or Ultra DMA mode of 5 to 7 acts as mode 4, and a DMA mode of 3 acts as mode 2.
- R8: When a request completes, `timing_reg` takes `word0` if `word0` is nonzero. Otherwise it takes `word1` if `word1` is nonzero. Otherwise it keeps its previous value.
- R9: When a request completes, `switch_en` becomes 1 exactly when both words are nonzero and differ from each other, and 0 otherwise.
- R10: `done` is high for exactly one cycle per request. The new `word0`, `word1`, `timing_reg` and `switch_en` are already on the outputs in the cycle before `done` rises.
- R11: A `start` pulse that arrives while a request is in progress is ignored, and the result reflects the inputs captured when that request began. A `start` in the cycle in which `done` is high is accepted as a new request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle request pulse, accepted only when idle |
| fast_mode | input | 1 | 1 selects 15 ns ticks, 0 selects 30 ns ticks |
| d0_present | input | 1 | Drive 0 is attached |
| d0_dma_en | input | 1 | Drive 0 uses multiword DMA |
| d0_udma_en | input | 1 | Drive 0 uses Ultra DMA (fast variant only) |
| d0_pio_mode | input | 3 | Drive 0 programmed I/O mode |
| d0_dma_mode | input | 2 | Drive 0 multiword DMA mode |
| d0_udma_mode | input | 3 | Drive 0 Ultra DMA mode |
| d1_present | input | 1 | Drive 1 is attached |
| d1_dma_en | input | 1 | Drive 1 uses multiword DMA |
| d1_udma_en | input | 1 | Drive 1 uses Ultra DMA (fast variant only) |
| d1_pio_mode | input | 3 | Drive 1 programmed I/O mode |
| d1_dma_mode | input | 2 | Drive 1 multiword DMA mode |
| d1_udma_mode | input | 3 | Drive 1 Ultra DMA mode |
| done | output | 1 | One-cycle completion pulse |
| word0 | output | 32 | Timing word for drive 0 |
| word1 | output | 32 | Timing word for drive 1 |
| timing_reg | output | 32 | Value held by the channel's timing register |
| switch_en | output | 1 | Reload the register on every drive select |

## Verification
Completion of one request and acceptance of the next can fall in the same cycle. The bench watches for `done`, raises `start` with a different configuration in that very cycle, and expects the second result to appear with the words already stable one cycle before the second `done`. The bench also fires a second `start` with changed inputs while a conversion is still under way. It judges from the final words that the block used the first configuration and discarded the second pulse.

// File: rtl/ata_tm_pkg.sv
// Package: shared constants, the per-drive configuration type and the
// nanosecond mode tables for the ATA timing word generator.
// Assumes mode numbers beyond a table's end saturate to its last entry.
package ata_tm_pkg;

    localparam int NUM_DRV  = 2;    // drives sharing one channel
    localparam int NUM_ITEM = 6;    // time values converted per drive
    localparam int NS_W     = 10;   // width of a nanosecond value
    localparam int TICK_W   = 6;    // width of a tick count
    localparam int DIV_W    = 5;    // width of the tick divisor
    localparam int WORD_W   = 32;   // width of a timing word

    localparam int LEG_TICK_NS  = 30;
    localparam int FAST_TICK_NS = 15;

    // Index of each converted time within a drive's tick vector
    localparam int IT_PC = 0;   // I/O cycle
    localparam int IT_PA = 1;   // I/O active
    localparam int IT_DC = 2;   // DMA cycle
    localparam int IT_DA = 3;   // DMA active
    localparam int IT_UC = 4;   // Ultra DMA cycle
    localparam int IT_UA = 5;   // Ultra DMA active

    // Field positions inside a timing word
    localparam int PACT_LSB     = 0;
    localparam int PREC_LSB     = 5;
    localparam int LEG_DACT_LSB = 11;
    localparam int LEG_DREC_LSB = 16;
    localparam int FST_DACT_LSB = 10;
    localparam int FST_DREC_LSB = 15;
    localparam int UEN_BIT      = 20;
    localparam int UCYC_LSB     = 21;
    localparam int UACT_LSB     = 25;

    // Recovery offsets of the legacy variant
    localparam int LEG_PREC_OFS = 4;
    localparam int LEG_DREC_OFS = 1;

    typedef struct packed {
        logic       present;
        logic       dma_en;
        logic       udma_en;
        logic [2:0] pio_mode;
        logic [1:0] dma_mode;
        logic [2:0] udma_mode;
    } drv_cfg_t;

    // I/O mode time lookup (cycle or active), saturating at mode 4
    function automatic logic [NS_W-1:0] pio_ns(input logic [2:0] m, input logic act);
        logic [2:0] s;
        s = (m > 3'd4) ? 3'd4 : m;
        case (s)
            3'd0:    return act ? NS_W'(180) : NS_W'(600);
            3'd1:    return act ? NS_W'(150) : NS_W'(390);
            3'd2:    return act ? NS_W'(105) : NS_W'(240);
            3'd3:    return act ? NS_W'(90)  : NS_W'(180);
            default: return act ? NS_W'(75)  : NS_W'(120);
        endcase
    endfunction

    // Multiword DMA mode time lookup, saturating at mode 2
    function automatic logic [NS_W-1:0] dma_ns(input logic [1:0] m, input logic act);
        case (m)
            2'd0:    return act ? NS_W'(240) : NS_W'(480);
            2'd1:    return act ? NS_W'(90)  : NS_W'(165);
            default: return act ? NS_W'(75)  : NS_W'(120);
        endcase
    endfunction

    // Ultra DMA mode time lookup, saturating at mode 4
    function automatic logic [NS_W-1:0] udma_ns(input logic [2:0] m, input logic act);
        logic [2:0] s;
        s = (m > 3'd4) ? 3'd4 : m;
        case (s)
            3'd0:    return act ? NS_W'(180) : NS_W'(120);
            3'd1:    return act ? NS_W'(150) : NS_W'(90);
            3'd2:    return act ? NS_W'(120) : NS_W'(60);
            3'd3:    return act ? NS_W'(90)  : NS_W'(45);
            default: return act ? NS_W'(90)  : NS_W'(30);
        endcase
    endfunction

    // Time in ns for one converted item of a drive
    function automatic logic [NS_W-1:0] item_ns(input logic [2:0] item, input drv_cfg_t c);
        case (item)
            3'd0:    return pio_ns(c.pio_mode, 1'b0);
            3'd1:    return pio_ns(c.pio_mode, 1'b1);
            3'd2:    return dma_ns(c.dma_mode, 1'b0);
            3'd3:    return dma_ns(c.dma_mode, 1'b1);
            3'd4:    return udma_ns(c.udma_mode, 1'b0);
            default: return udma_ns(c.udma_mode, 1'b1);
        endcase
    endfunction

endpackage

// File: rtl/ata_tm_div.sv
// Module: sequential restoring divider that returns ceil(dividend/divisor).
// One bit of quotient per cycle; the result is valid for one cycle, NS_W+1
// cycles after go. Assumes go is only raised while no division is running
// and that divisor is nonzero.
module ata_tm_div #(
    parameter int NS_W   = ata_tm_pkg::NS_W,
    parameter int DIV_W  = ata_tm_pkg::DIV_W,
    parameter int TICK_W = ata_tm_pkg::TICK_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [NS_W-1:0]   dividend,
    input  logic [DIV_W-1:0]  divisor,
    output logic              valid,
    output logic [TICK_W-1:0] ceil_q
);
    localparam int CNT_W = $clog2(NS_W + 1);

    logic              active_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [NS_W-1:0]   dvd_q;
    logic [NS_W-1:0]   orig_q;
    logic [NS_W-1:0]   quo_q;
    logic [DIV_W-1:0]  rem_q;
    logic [DIV_W-1:0]  dsr_q;
    logic              valid_q;
    logic [DIV_W:0]    trial;
    logic [DIV_W:0]    diff;
    logic              fits;

    // Trial subtraction of the divisor from the shifted partial remainder
    always_comb begin
        trial = {rem_q, dvd_q[NS_W-1]};
        diff  = trial - {1'b0, dsr_q};
        fits  = (trial >= {1'b0, dsr_q});
    end

    // Iteration registers: load on go, then one quotient bit per cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            cnt_q    <= '0;
            dvd_q    <= '0;
            orig_q   <= '0;
            quo_q    <= '0;
            rem_q    <= '0;
            dsr_q    <= '0;
            valid_q  <= 1'b0;
        end else begin
            valid_q <= 1'b0;
            if (go && !active_q) begin
                active_q <= 1'b1;
                cnt_q    <= CNT_W'(NS_W);
                dvd_q    <= dividend;
                orig_q   <= dividend;
                quo_q    <= '0;
                rem_q    <= '0;
                dsr_q    <= divisor;
            end else if (active_q) begin
                dvd_q <= {dvd_q[NS_W-2:0], 1'b0};
                quo_q <= {quo_q[NS_W-2:0], fits};
                rem_q <= fits ? diff[DIV_W-1:0] : trial[DIV_W-1:0];
                cnt_q <= cnt_q - 1'b1;
                if (cnt_q == CNT_W'(1)) begin
                    active_q <= 1'b0;
                    valid_q  <= 1'b1;
                end
            end
        end
    end

    // Round the quotient up when a remainder is left
    assign valid  = valid_q;
    assign ceil_q = TICK_W'(quo_q + NS_W'(rem_q != '0));

    // Quotient and remainder reproduce the dividend (ceiling division, R2)
    assert_div_exact_R2: assert property (@(posedge clk) disable iff (!rst_n)
        valid_q |-> ((2*NS_W)'(quo_q) * (2*NS_W)'(dsr_q) + (2*NS_W)'(rem_q) == (2*NS_W)'(orig_q)));

    // The remainder left over is below the divisor (R4)
    assert_div_rem_R4: assert property (@(posedge clk) disable iff (!rst_n)
        valid_q |-> (rem_q < dsr_q));

endmodule

// File: rtl/ata_tm_seq.sv
// Module: request sequencer. Captures the drive configuration and variant
// on an accepted start, walks all time items of both drives through the
// shared divider, stores the tick counts, then signals the word load and the
// finish cycle. Assumes the divider answers each go with exactly one valid.
module ata_tm_seq
    import ata_tm_pkg::*;
#(
    parameter int N_DRV  = NUM_DRV,
    parameter int N_ITEM = NUM_ITEM,
    parameter int T_W    = TICK_W,
    parameter int N_W    = NS_W,
    parameter int D_W    = DIV_W
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                start,
    input  logic                                fast_in,
    input  drv_cfg_t [N_DRV-1:0]                cfg_in,
    input  logic                                div_valid,
    input  logic [T_W-1:0]                      div_ceil,
    output logic                                div_go,
    output logic [N_W-1:0]                      div_dividend,
    output logic [D_W-1:0]                      div_divisor,
    output drv_cfg_t [N_DRV-1:0]                cfg_q,
    output logic                                fast_q,
    output logic [N_DRV-1:0][N_ITEM-1:0][T_W-1:0] ticks_q,
    output logic                                load_words,
    output logic                                fin
);
    localparam int DRV_IW  = (N_DRV > 1) ? $clog2(N_DRV) : 1;
    localparam int ITEM_IW = 3;

    typedef enum logic [2:0] {S_IDLE, S_ISSUE, S_WAIT, S_WORD, S_FIN} seq_state_e;

    seq_state_e          state_q;
    logic [DRV_IW-1:0]   drv_q;
    logic [ITEM_IW-1:0]  item_q;
    logic                last_item;
    logic                last_drv;

    // Position flags for the end of the conversion walk
    always_comb begin
        last_item = (item_q == ITEM_IW'(N_ITEM - 1));
        last_drv  = (drv_q == DRV_IW'(N_DRV - 1));
    end

    // Divider request for the current drive and item
    always_comb begin
        div_go       = (state_q == S_ISSUE);
        div_dividend = item_ns(item_q, cfg_q[drv_q]);
        div_divisor  = fast_q ? D_W'(FAST_TICK_NS) : D_W'(LEG_TICK_NS);
        load_words   = (state_q == S_WORD);
        fin          = (state_q == S_FIN);
    end

    // Sequencer state, captured request and tick storage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            drv_q   <= '0;
            item_q  <= '0;
            cfg_q   <= '0;
            fast_q  <= 1'b0;
            ticks_q <= '0;
        end else begin
            case (state_q)
                S_IDLE: begin
                    if (start) begin
                        cfg_q   <= cfg_in;
                        fast_q  <= fast_in;
                        drv_q   <= '0;
                        item_q  <= '0;
                        state_q <= S_ISSUE;
                    end
                end
                S_ISSUE: state_q <= S_WAIT;
                S_WAIT: begin
                    if (div_valid) begin
                        ticks_q[drv_q][item_q] <= div_ceil;
                        if (!last_item) begin
                            item_q  <= item_q + 1'b1;
                            state_q <= S_ISSUE;
                        end else if (!last_drv) begin
                            item_q  <= '0;
                            drv_q   <= drv_q + 1'b1;
                            state_q <= S_ISSUE;
                        end else begin
                            state_q <= S_WORD;
                        end
                    end
                end
                S_WORD:  state_q <= S_FIN;
                default: state_q <= S_IDLE;
            endcase
        end
    end

    // A start during a running request leaves the captured request alone (R11)
    assert_busy_ignore_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != S_IDLE && start) |=> ($stable(cfg_q) && $stable(fast_q)));

endmodule

// File: rtl/ata_tm_pack.sv
// Module: combinational packer. From the tick counts of each drive and the
// captured flags it derives recovery counts with the variant's offsets and
// clamps and assembles one timing word per drive. Assumes tick counts fit
// their fields, which holds for every mode in the tables.
module ata_tm_pack
    import ata_tm_pkg::*;
#(
    parameter int N_DRV  = NUM_DRV,
    parameter int N_ITEM = NUM_ITEM,
    parameter int T_W    = TICK_W,
    parameter int W_W    = WORD_W
) (
    input  logic                                fast,
    input  drv_cfg_t [N_DRV-1:0]                cfg,
    input  logic [N_DRV-1:0][N_ITEM-1:0][T_W-1:0] ticks,
    output logic [N_DRV-1:0][W_W-1:0]           words
);
    localparam int RW = T_W + 2;
    localparam logic signed [RW-1:0] ONE  = RW'(1);
    localparam logic signed [RW-1:0] POFS = RW'(LEG_PREC_OFS);
    localparam logic signed [RW-1:0] DOFS = RW'(LEG_DREC_OFS);

    for (genvar g = 0; g < N_DRV; g++) begin : g_drv
        logic signed [RW-1:0] pc, pa, pa_c, prec, dc, da, drec;
        logic [W_W-1:0]       w;

        // Recovery arithmetic and field assembly for one drive
        always_comb begin
            pc = $signed({2'b00, ticks[g][IT_PC]});
            pa = $signed({2'b00, ticks[g][IT_PA]});
            dc = $signed({2'b00, ticks[g][IT_DC]});
            da = $signed({2'b00, ticks[g][IT_DA]});
            if (fast) begin
                pa_c = pa;
                prec = pc - pa;
                drec = dc - da;
            end else begin
                pa_c = (pa < ONE) ? ONE : pa;
                prec = pc - pa_c - POFS;
                if (prec < ONE) prec = ONE;
                drec = dc - da - DOFS;
                if (drec < ONE) drec = ONE;
            end
            w = '0;
            if (cfg[g].present) begin
                w = w | (W_W'($unsigned(pa_c)) << PACT_LSB)
                      | (W_W'($unsigned(prec)) << PREC_LSB);
                if (cfg[g].dma_en) begin
                    if (fast)
                        w = w | (W_W'($unsigned(da))   << FST_DACT_LSB)
                              | (W_W'($unsigned(drec)) << FST_DREC_LSB);
                    else
                        w = w | (W_W'($unsigned(da))   << LEG_DACT_LSB)
                              | (W_W'($unsigned(drec)) << LEG_DREC_LSB);
                end
                if (cfg[g].udma_en && fast) begin
                    w = w | (W_W'(1) << UEN_BIT)
                          | (W_W'(ticks[g][IT_UC]) << UCYC_LSB)
                          | (W_W'(ticks[g][IT_UA]) << UACT_LSB);
                end
            end
        end

        assign words[g] = w;
    end

endmodule

// File: rtl/ata_tm_sel.sv
// Module: channel register selection. Picks the word the shared timing
// register holds and whether it must be reloaded on each drive select.
// Assumes exactly two drives; keeps the current value when both are zero.
module ata_tm_sel #(
    parameter int W_W = ata_tm_pkg::WORD_W
) (
    input  logic [W_W-1:0] w0,
    input  logic [W_W-1:0] w1,
    input  logic [W_W-1:0] cur_reg,
    output logic [W_W-1:0] nxt_reg,
    output logic           nxt_switch
);
    logic nz0, nz1;

    // Priority choice: drive 0 first, then drive 1, else hold
    always_comb begin
        nz0        = (w0 != '0);
        nz1        = (w1 != '0);
        nxt_reg    = nz0 ? w0 : (nz1 ? w1 : cur_reg);
        nxt_switch = nz0 && nz1 && (w0 != w1);
    end

endmodule

// File: rtl/ata_timing_gen.sv
// Module: top of the ATA drive timing word generator. Connects the
// sequencer, shared divider, packer and register selection, and holds the
// result registers and the done pulse. Assumes start is a one-cycle pulse;
// results hold until the next request completes.
module ata_timing_gen
    import ata_tm_pkg::*;
#(
    parameter int W_W = WORD_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic           fast_mode,
    input  logic           d0_present,
    input  logic           d0_dma_en,
    input  logic           d0_udma_en,
    input  logic [2:0]     d0_pio_mode,
    input  logic [1:0]     d0_dma_mode,
    input  logic [2:0]     d0_udma_mode,
    input  logic           d1_present,
    input  logic           d1_dma_en,
    input  logic           d1_udma_en,
    input  logic [2:0]     d1_pio_mode,
    input  logic [1:0]     d1_dma_mode,
    input  logic [2:0]     d1_udma_mode,
    output logic           done,
    output logic [W_W-1:0] word0,
    output logic [W_W-1:0] word1,
    output logic [W_W-1:0] timing_reg,
    output logic           switch_en
);
    drv_cfg_t [NUM_DRV-1:0]                      cfg_in, cfg_q;
    logic                                        fast_q;
    logic [NUM_DRV-1:0][NUM_ITEM-1:0][TICK_W-1:0] ticks;
    logic [NUM_DRV-1:0][W_W-1:0]                 words_nxt;
    logic                                        div_go, div_valid;
    logic [NS_W-1:0]                             div_dividend;
    logic [DIV_W-1:0]                            div_divisor;
    logic [TICK_W-1:0]                           div_ceil;
    logic                                        load_words, fin;
    logic [W_W-1:0]                              reg_nxt;
    logic                                        sw_nxt;
    logic                                        done_q, sw_q;
    logic [W_W-1:0]                              w0_q, w1_q, reg_q;

    // Gather the per-drive input pins into configuration records
    always_comb begin
        cfg_in[0] = '{present: d0_present, dma_en: d0_dma_en, udma_en: d0_udma_en,
                      pio_mode: d0_pio_mode, dma_mode: d0_dma_mode, udma_mode: d0_udma_mode};
        cfg_in[1] = '{present: d1_present, dma_en: d1_dma_en, udma_en: d1_udma_en,
                      pio_mode: d1_pio_mode, dma_mode: d1_dma_mode, udma_mode: d1_udma_mode};
    end

    ata_tm_seq i_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .fast_in      (fast_mode),
        .cfg_in       (cfg_in),
        .div_valid    (div_valid),
        .div_ceil     (div_ceil),
        .div_go       (div_go),
        .div_dividend (div_dividend),
        .div_divisor  (div_divisor),
        .cfg_q        (cfg_q),
        .fast_q       (fast_q),
        .ticks_q      (ticks),
        .load_words   (load_words),
        .fin          (fin)
    );

    ata_tm_div i_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .go       (div_go),
        .dividend (div_dividend),
        .divisor  (div_divisor),
        .valid    (div_valid),
        .ceil_q   (div_ceil)
    );

    ata_tm_pack #(.W_W(W_W)) i_pack (
        .fast  (fast_q),
        .cfg   (cfg_q),
        .ticks (ticks),
        .words (words_nxt)
    );

    ata_tm_sel #(.W_W(W_W)) i_sel (
        .w0         (words_nxt[0]),
        .w1         (words_nxt[1]),
        .cur_reg    (reg_q),
        .nxt_reg    (reg_nxt),
        .nxt_switch (sw_nxt)
    );

    // Result registers load one cycle before the done pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            w0_q   <= '0;
            w1_q   <= '0;
            reg_q  <= '0;
            sw_q   <= 1'b0;
        end else begin
            done_q <= fin;
            if (load_words) begin
                w0_q  <= words_nxt[0];
                w1_q  <= words_nxt[1];
                reg_q <= reg_nxt;
                sw_q  <= sw_nxt;
            end
        end
    end

    assign done       = done_q;
    assign word0      = w0_q;
    assign word1      = w1_q;
    assign timing_reg = reg_q;
    assign switch_en  = sw_q;

    // Done never lasts two cycles (R10)
    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);

    // Results are already settled in the cycle before done (R10)
    assert_words_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> ($stable(w0_q) && $stable(w1_q) && $stable(reg_q) && $stable(sw_q)));

    // Per-select switching implies the register holds drive 0's word (R9)
    assert_switch_reg_R9: assert property (@(posedge clk) disable iff (!rst_n)
        sw_q |-> (reg_q == w0_q && w0_q != w1_q && w1_q != '0));

    // The register always holds one of the words unless both are zero (R8)
    assert_reg_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> (reg_q == w0_q || (w0_q == '0 && (reg_q == w1_q || w1_q == '0))));

    // Legacy words leave the upper bits clear (R3)
    assert_legacy_high_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (done_q && !fast_q) |-> (w0_q[W_W-1:21] == '0 && w1_q[W_W-1:21] == '0));

    // An absent drive yields a zero word (R6)
    assert_absent_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done_q && !cfg_q[0].present) |-> (w0_q == '0));

    // Fast variant with Ultra DMA sets the enable bit (R5)
    assert_udma_enable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (done_q && fast_q && cfg_q[0].present && cfg_q[0].udma_en) |-> w0_q[20]);

endmodule

// File: tb/test_ata_timing_gen.sv
// Bench: vector table walked by one loop, then directed tests for reset,
// busy start, start in the done cycle and done timing.
module test_ata_timing_gen;

    typedef struct packed {
        logic        fast;
        logic [10:0] c0;
        logic [10:0] c1;
        logic [31:0] e0;
        logic [31:0] e1;
        logic [31:0] er;
        logic        es;
    } vec_t;

    // cfg bits: [10] present, [9] dma, [8] udma, [7:5] pio, [4:3] dma mode, [2:0] udma mode
    function automatic logic [10:0] mk(input int p, input int d, input int u,
                                       input int pm, input int dm, input int um);
        return {p[0], d[0], u[0], pm[2:0], dm[1:0], um[2:0]};
    endfunction

    localparam int NV = 13;
    localparam vec_t TV [NV] = '{
        '{1'b0, mk(1,0,0,0,0,0), mk(0,0,0,0,0,0), 32'h146,      32'h0,        32'h146,      1'b0}, // R2 mode0
        '{1'b0, mk(1,0,0,2,0,0), mk(1,0,0,3,0,0), 32'h24,       32'h23,       32'h24,       1'b1}, // R2 clamp, R9
        '{1'b0, mk(1,1,0,4,0,0), mk(1,1,0,1,1,0), 32'h74023,    32'h21885,    32'h74023,    1'b1}, // R3
        '{1'b0, mk(1,1,1,3,2,0), mk(1,1,1,3,2,0), 32'h11823,    32'h11823,    32'h11823,    1'b0}, // R3 udma ignored, R9 equal
        '{1'b1, mk(1,1,0,0,0,0), mk(1,1,0,1,1,0), 32'h8438C,    32'h29A0A,    32'h8438C,    1'b1}, // R4
        '{1'b1, mk(1,1,1,2,2,0), mk(1,0,1,3,0,1), 32'h19119527, 32'h14D000C6, 32'h19119527, 1'b1}, // R5
        '{1'b1, mk(1,0,1,4,0,2), mk(1,0,1,4,0,3), 32'h10900065, 32'h0C700065, 32'h10900065, 1'b1}, // R5
        '{1'b1, mk(0,1,1,0,0,0), mk(1,0,1,4,0,4), 32'h0,        32'h0C500065, 32'h0C500065, 1'b0}, // R6 R8 absent drive 0
        '{1'b1, mk(1,1,1,7,3,7), mk(1,0,0,5,0,0), 32'h0C519465, 32'h65,       32'h0C519465, 1'b1}, // R7 fast saturation
        '{1'b0, mk(1,1,0,6,3,0), mk(0,1,1,1,1,1), 32'h11823,    32'h0,        32'h11823,    1'b0}, // R7 legacy saturation
        '{1'b1, mk(0,0,0,0,0,0), mk(0,1,0,2,0,0), 32'h0,        32'h0,        32'h11823,    1'b0}, // R8 hold
        '{1'b0, mk(1,0,0,1,0,0), mk(1,0,0,1,0,0), 32'h85,       32'h85,       32'h85,       1'b0}, // R6 DMA off, R9 equal
        '{1'b1, mk(1,0,0,0,0,0), mk(0,0,0,0,0,0), 32'h38C,      32'h0,        32'h38C,      1'b0}  // R4 PIO only
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        fast_mode = 1'b0;
    logic [10:0] cfg0 = '0;
    logic [10:0] cfg1 = '0;
    logic        done;
    logic [31:0] word0, word1, timing_reg;
    logic        switch_en;

    int n_chk  = 0;
    int n_fail = 0;
    int cycles = 0;

    always #4 clk = ~clk;   // 125 MHz

    ata_timing_gen i_ata_timing_gen (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .fast_mode    (fast_mode),
        .d0_present   (cfg0[10]),
        .d0_dma_en    (cfg0[9]),
        .d0_udma_en   (cfg0[8]),
        .d0_pio_mode  (cfg0[7:5]),
        .d0_dma_mode  (cfg0[4:3]),
        .d0_udma_mode (cfg0[2:0]),
        .d1_present   (cfg1[10]),
        .d1_dma_en    (cfg1[9]),
        .d1_udma_en   (cfg1[8]),
        .d1_pio_mode  (cfg1[7:5]),
        .d1_dma_mode  (cfg1[4:3]),
        .d1_udma_mode (cfg1[2:0]),
        .done         (done),
        .word0        (word0),
        .word1        (word1),
        .timing_reg   (timing_reg),
        .switch_en    (switch_en)
    );

    // Watchdog: a hung run counts as a failed check
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            n_chk  = n_chk + 1;
            n_fail = n_fail + 1;
            $display("FAIL watchdog: run did not finish, actual cycles %0d expected below 150000", cycles);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk = n_chk + 1;
        if (act !== exp) begin
            n_fail = n_fail + 1;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic pulse_start(input logic f, input logic [10:0] a, input logic [10:0] b);
        fast_mode = f;
        cfg0      = a;
        cfg1      = b;
        start     = 1'b1;
        @(negedge clk);
        start     = 1'b0;
    endtask

    // Wait for done; prev_w0 is word0 one cycle before done
    task automatic wait_done(output logic [31:0] prev_w0);
        int guard = 0;
        prev_w0 = word0;
        while (done !== 1'b1 && guard < 2000) begin
            prev_w0 = word0;
            @(negedge clk);
            guard++;
        end
        check("R10 done seen", {31'b0, done}, 32'd1);
    endtask

    initial begin
        logic [31:0] prev;
        repeat (4) @(negedge clk);
        // R1: reset state
        check("R1 done", {31'b0, done}, 32'd0);
        check("R1 word0", word0, 32'd0);
        check("R1 word1", word1, 32'd0);
        check("R1 timing_reg", timing_reg, 32'd0);
        check("R1 switch_en", {31'b0, switch_en}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // Vector table: R2 R3 R4 R5 R6 R7 R8 R9
        for (int i = 0; i < NV; i++) begin
            pulse_start(TV[i].fast, TV[i].c0, TV[i].c1);
            wait_done(prev);
            check($sformatf("vec %0d word0 (R2-style fields, R6 R7)", i), word0, TV[i].e0);
            check($sformatf("vec %0d word1 (R3 R4 R5)", i), word1, TV[i].e1);
            check($sformatf("vec %0d timing_reg R8", i), timing_reg, TV[i].er);
            check($sformatf("vec %0d switch_en R9", i), {31'b0, switch_en}, {31'b0, TV[i].es});
            @(negedge clk);
            check($sformatf("vec %0d done one cycle R10", i), {31'b0, done}, 32'd0);
        end

        // R11: start while busy is ignored
        pulse_start(1'b1, mk(1,0,0,0,0,0), mk(0,0,0,0,0,0));
        repeat (5) @(negedge clk);
        pulse_start(1'b0, mk(1,0,0,0,0,0), mk(1,0,0,4,0,0));
        wait_done(prev);
        check("R11 busy start ignored word0", word0, 32'h38C);
        check("R11 busy start ignored word1", word1, 32'h0);

        // R11: start in the done cycle is accepted; R10 word settles a cycle early
        pulse_start(1'b0, mk(1,0,0,0,0,0), mk(1,0,0,4,0,0));
        wait_done(prev);
        check("R10 word0 settled before done", prev, 32'h146);
        check("R11 done-cycle start word0", word0, 32'h146);
        check("R11 done-cycle start word1", word1, 32'h23);
        check("R9 differing words switch", {31'b0, switch_en}, 32'd1);
        @(negedge clk);
        check("R10 done dropped", {31'b0, done}, 32'd0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule